// File: doc/BRIEF.md
# Register-Mapped Network Port

This block lets an in-order processor pipeline treat on-chip network channels as register names. When the execute stage holds an instruction whose destination is the network register, and that instruction is not flushed, its result is pushed into an outbound queue. The router drains that queue strictly oldest first. When the decode stage holds an instruction that names the network register as a source, the oldest word in the inbound queue is handed to the operand path and popped. If the queue is empty, decode is stalled until a word arrives.

Execute is the commit point. A flush that is raised in the same cycle cancels the outbound push, so a speculative value never reaches the network. A dual-destination bit in the instruction sends the committed result to the network and also to a named local register. The local register write leaves the block through a registered write port one cycle later. When the outbound queue is full, a network write holds the pipeline and is not lost. Both router-facing sides use valid/ready handshakes.

Top module: `rmn_port`

## Requirements
- R1: During and just after reset, `net_out_valid`, `lcl_we`, `pipe_stall` and `dec_stall` are 0 and `net_in_ready` is 1.
- R2: A network write is committed when `ex_valid`=1, `ex_wr_net`=1, `ex_flush`=0 and the outbound queue is not full. Into an empty outbound queue, the committed value shows on `net_out_data` with `net_out_valid`=1 in the cycle after the commit edge.
- R3: Words leave on the outbound side in commit order. While `net_out_valid`=1 and `net_out_ready`=0, `net_out_valid` and `net_out_data` hold.
- R4: An execute-stage network write with `ex_flush`=1 pushes nothing and produces no local write. A flushed value never appears on `net_out_data`.
- R5: The outbound queue holds 4 words. A network write into a full queue raises `pipe_stall` for as long as the queue stays full. The write is taken once space exists and is not dropped.
- R6: A committed network write with `ex_dual`=1 gives `lcl_we`=1, `lcl_idx`=`ex_idx` and `lcl_data`=`ex_result` in the cycle after the commit edge. With `ex_dual`=0, `lcl_we` stays 0.
- R7: When `dec_rd_net`=1 and the inbound queue is not empty, `dec_data` shows the oldest inbound word and `dec_stall`=0. The word is popped at the next edge.
- R8: When `dec_rd_net`=1 and the inbound queue is empty, `dec_stall`=1 and nothing is popped.
- R9: The inbound queue holds 4 words. `net_in_ready`=0 while it is full, and a word offered while `net_in_ready`=0 is ignored.
- R10: While `pipe_stall`=1, a decode-stage network read does not pop. `dec_data` keeps the same word until the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rd_net | input | 1 | Decode-stage instruction reads the network register |
| dec_stall | output | 1 | Decode must hold: inbound queue empty |
| dec_data | output | 32 | Oldest inbound word for the operand path |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| ex_wr_net | input | 1 | Execute-stage instruction writes the network register |
| ex_dual | input | 1 | Also write the result to a local register |
| ex_flush | input | 1 | Execute-stage instruction is squashed |
| ex_idx | input | 5 | Local destination register index |
| ex_result | input | 32 | Execute-stage result |
| pipe_stall | output | 1 | Pipeline hold: network write into a full queue |
| lcl_we | output | 1 | Registered local register write enable |
| lcl_idx | output | 5 | Registered local register index |
| lcl_data | output | 32 | Registered local register data |
| net_out_valid | output | 1 | Outbound word available to the router |
| net_out_data | output | 32 | Outbound word |
| net_out_ready | input | 1 | Router accepts the outbound word |
| net_in_valid | input | 1 | Router offers an inbound word |
| net_in_data | input | 32 | Inbound word |
| net_in_ready | output | 1 | Inbound queue has room |

## Verification
Every cycle, the assertions check that the outbound word holds while it is back-pressured and that a stall is raised only with a non-empty outbound queue. They also check that a local write follows only a committed dual-destination instruction, that no word appears out of an empty queue without a commit, and that no inbound pop happens during a pipeline stall. Three behaviours need the bench's scenarios: commit order across a fill-and-drain sequence, the absence of flushed values from the delivered stream, and the survival of a write that was held while the queue was full. The same holds for the inbound word order and for a word dropped at full capacity.

// File: rtl/rmn_pkg.sv
package rmn_pkg;
  localparam int unsigned DEF_DW    = 32;
  localparam int unsigned DEF_IW    = 5;
  localparam int unsigned DEF_DEPTH = 4;

  typedef struct packed {
    logic push;
    logic stall;
  } commit_t;
endpackage

// File: rtl/rmn_fifo.sv
module rmn_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/rmn_commit.sv
module rmn_commit
  import rmn_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ex_valid,
  input  logic          ex_wr_net,
  input  logic          ex_dual,
  input  logic          ex_flush,
  input  logic [IW-1:0] ex_idx,
  input  logic [DW-1:0] ex_result,
  input  logic          ob_full,
  output commit_t       cmt,
  output logic          lcl_we,
  output logic [IW-1:0] lcl_idx,
  output logic [DW-1:0] lcl_data
);
  logic net_req;

  // execute is the commit point: a flush here cancels the push
  assign net_req   = ex_valid && ex_wr_net && !ex_flush;
  assign cmt.push  = net_req && !ob_full;
  assign cmt.stall = net_req && ob_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcl_we   <= 1'b0;
      lcl_idx  <= '0;
      lcl_data <= '0;
    end else begin
      lcl_we <= cmt.push && ex_dual;
      if (cmt.push && ex_dual) begin
        lcl_idx  <= ex_idx;
        lcl_data <= ex_result;
      end
    end
  end
endmodule

// File: rtl/rmn_recv.sv
module rmn_recv (
  input  logic dec_rd_net,
  input  logic ib_empty,
  input  logic pipe_stall,
  output logic dec_stall,
  output logic ib_pop
);
  assign dec_stall = dec_rd_net && ib_empty;
  assign ib_pop    = dec_rd_net && !ib_empty && !pipe_stall;
endmodule

// File: rtl/rmn_port.sv
module rmn_port
  import rmn_pkg::*;
#(
  parameter int unsigned DW    = DEF_DW,
  parameter int unsigned IW    = DEF_IW,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_rd_net,
  output logic          dec_stall,
  output logic [DW-1:0] dec_data,
  input  logic          ex_valid,
  input  logic          ex_wr_net,
  input  logic          ex_dual,
  input  logic          ex_flush,
  input  logic [IW-1:0] ex_idx,
  input  logic [DW-1:0] ex_result,
  output logic          pipe_stall,
  output logic          lcl_we,
  output logic [IW-1:0] lcl_idx,
  output logic [DW-1:0] lcl_data,
  output logic          net_out_valid,
  output logic [DW-1:0] net_out_data,
  input  logic          net_out_ready,
  input  logic          net_in_valid,
  input  logic [DW-1:0] net_in_data,
  output logic          net_in_ready
);
  commit_t cmt;
  logic    ob_empty, ob_full, ib_empty, ib_full, ib_pop;

  rmn_commit #(.DW(DW), .IW(IW)) u_commit (
    .clk(clk), .rst(rst),
    .ex_valid(ex_valid), .ex_wr_net(ex_wr_net), .ex_dual(ex_dual),
    .ex_flush(ex_flush), .ex_idx(ex_idx), .ex_result(ex_result),
    .ob_full(ob_full), .cmt(cmt),
    .lcl_we(lcl_we), .lcl_idx(lcl_idx), .lcl_data(lcl_data)
  );

  rmn_fifo #(.DW(DW), .DEPTH(DEPTH)) u_obq (
    .clk(clk), .rst(rst),
    .push(cmt.push), .din(ex_result),
    .pop(net_out_ready), .head(net_out_data),
    .empty(ob_empty), .full(ob_full)
  );

  rmn_fifo #(.DW(DW), .DEPTH(DEPTH)) u_ibq (
    .clk(clk), .rst(rst),
    .push(net_in_valid), .din(net_in_data),
    .pop(ib_pop), .head(dec_data),
    .empty(ib_empty), .full(ib_full)
  );

  rmn_recv u_recv (
    .dec_rd_net(dec_rd_net), .ib_empty(ib_empty), .pipe_stall(pipe_stall),
    .dec_stall(dec_stall), .ib_pop(ib_pop)
  );

  assign pipe_stall    = cmt.stall;
  assign net_out_valid = !ob_empty;
  assign net_in_ready  = !ib_full;
endmodule

// File: rtl/rmn_port_chk.sv
module rmn_port_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_stall,
  input logic          ex_valid,
  input logic          ex_wr_net,
  input logic          ex_dual,
  input logic          ex_flush,
  input logic          pipe_stall,
  input logic          lcl_we,
  input logic          net_out_valid,
  input logic [DW-1:0] net_out_data,
  input logic          net_out_ready,
  input logic          net_in_ready,
  input logic          ib_pop
);
  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    net_out_valid && !net_out_ready |=> net_out_valid && $stable(net_out_data));

  // R4
  no_inject_chk: assert property (@(posedge clk) disable iff (rst)
    !net_out_valid && !(ex_valid && ex_wr_net && !ex_flush) |=> !net_out_valid);

  // R5
  stall_full_chk: assert property (@(posedge clk) disable iff (rst)
    pipe_stall |-> net_out_valid);

  // R6
  local_copy_chk: assert property (@(posedge clk) disable iff (rst)
    lcl_we |-> $past(ex_valid && ex_wr_net && ex_dual && !ex_flush && !pipe_stall));

  // R8
  empty_stall_chk: assert property (@(posedge clk) disable iff (rst)
    dec_stall |-> net_in_ready);

  // R10
  no_pop_stall_chk: assert property (@(posedge clk) disable iff (rst)
    pipe_stall |-> !ib_pop);
endmodule

bind rmn_port rmn_port_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .dec_stall(dec_stall),
  .ex_valid(ex_valid), .ex_wr_net(ex_wr_net), .ex_dual(ex_dual),
  .ex_flush(ex_flush), .pipe_stall(pipe_stall), .lcl_we(lcl_we),
  .net_out_valid(net_out_valid), .net_out_data(net_out_data),
  .net_out_ready(net_out_ready), .net_in_ready(net_in_ready),
  .ib_pop(ib_pop)
);

// File: tb/test_rmn_port.sv
module test_rmn_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_rd_net = 1'b0;
  logic        dec_stall;
  logic [31:0] dec_data;
  logic        ex_valid = 1'b0, ex_wr_net = 1'b0, ex_dual = 1'b0, ex_flush = 1'b0;
  logic [4:0]  ex_idx = '0;
  logic [31:0] ex_result = '0;
  logic        pipe_stall, lcl_we;
  logic [4:0]  lcl_idx;
  logic [31:0] lcl_data;
  logic        net_out_valid;
  logic [31:0] net_out_data;
  logic        net_out_ready = 1'b0;
  logic        net_in_valid = 1'b0;
  logic [31:0] net_in_data = '0;
  logic        net_in_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] sb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rmn_port i_rmn_port (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard of delivered outbound words (R3, R4)
  always @(negedge clk) begin
    if (!rst && net_out_valid && net_out_ready) begin
      if (sb.size() == 0) chk(0, "R4 unexpected word", net_out_data, 32'h0);
      else begin
        logic [31:0] e;
        e = sb.pop_front();
        chk(net_out_data == e, "R3 order", net_out_data, e);
      end
    end
  end

  // driver: execute-stage network write, held until accepted
  task automatic net_wr(input logic [31:0] d, input logic dual, input logic [4:0] idx, input logic fl);
    bit st;
    ex_valid = 1; ex_wr_net = 1; ex_dual = dual; ex_idx = idx; ex_result = d; ex_flush = fl;
    do begin
      @(negedge clk); st = pipe_stall;
      @(posedge clk); #1;
    end while (st);
    if (!fl) sb.push_back(d);
    ex_valid = 0; ex_wr_net = 0; ex_dual = 0; ex_flush = 0;
  endtask

  task automatic in_word(input logic [31:0] d);
    net_in_valid = 1; net_in_data = d;
    @(posedge clk); #1;
    net_in_valid = 0;
  endtask

  task automatic rd_net(input logic [31:0] exp, input string req);
    dec_rd_net = 1;
    @(negedge clk);
    chk(dec_stall == 0, req, {31'b0, dec_stall}, 32'h0);
    chk(dec_data == exp, req, dec_data, exp);
    @(posedge clk); #1;
    dec_rd_net = 0;
  endtask

  task automatic drain;
    net_out_ready = 1;
    for (int i = 0; i < 40 && sb.size() != 0; i++) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    chk(sb.size() == 0, "R5 all words delivered", sb.size(), 32'h0);
    chk(net_out_valid == 0, "R3 queue empty after drain", {31'b0, net_out_valid}, 32'h0);
    net_out_ready = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(net_out_valid == 0 && lcl_we == 0, "R1 outputs idle in reset", {net_out_valid, lcl_we}, 0);
    rst = 0;
    @(negedge clk);
    chk(pipe_stall == 0 && dec_stall == 0, "R1 no stall", {pipe_stall, dec_stall}, 0);
    chk(net_in_ready == 1, "R1 in ready", {31'b0, net_in_ready}, 1);
    @(posedge clk); #1;

    // R2 single write latency
    net_wr(32'hA000_0001, 0, 5'd0, 0);
    @(negedge clk);
    chk(net_out_valid == 1, "R2 valid after commit", {31'b0, net_out_valid}, 1);
    chk(net_out_data == 32'hA000_0001, "R2 data", net_out_data, 32'hA000_0001);
    chk(lcl_we == 0, "R6 no local copy without dual", {31'b0, lcl_we}, 0);
    @(posedge clk); #1;

    // R4 flushed write, then more writes to fill
    net_wr(32'hDEAD_0002, 0, 5'd0, 1);
    @(negedge clk);
    chk(lcl_we == 0, "R4 flush no local write", {31'b0, lcl_we}, 0);
    @(posedge clk); #1;
    net_wr(32'hA000_0003, 0, 5'd0, 0);
    net_wr(32'hA000_0004, 0, 5'd0, 0);
    net_wr(32'hDEAD_0005, 1, 5'd3, 1);
    net_wr(32'hA000_0006, 0, 5'd0, 0);

    // R5 full queue stalls, write survives
    fork
      net_wr(32'hA000_0007, 0, 5'd0, 0);
      begin
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk(pipe_stall == 1, "R5 stall when full", {31'b0, pipe_stall}, 1);
        end
        @(posedge clk); #1;
        net_out_ready = 1;
      end
    join
    drain();

    // R6 dual destination
    net_out_ready = 1;
    net_wr(32'hB0B0_1234, 1, 5'd17, 0);
    @(negedge clk);
    chk(lcl_we == 1, "R6 local write", {31'b0, lcl_we}, 1);
    chk(lcl_idx == 5'd17, "R6 local idx", {27'b0, lcl_idx}, 17);
    chk(lcl_data == 32'hB0B0_1234, "R6 local data", lcl_data, 32'hB0B0_1234);
    @(posedge clk); #1;
    net_wr(32'hDEAD_0008, 1, 5'd9, 1);
    @(negedge clk);
    chk(lcl_we == 0, "R4 flushed dual gives no local write", {31'b0, lcl_we}, 0);
    @(posedge clk); #1;
    drain();

    // R7 / R8 inbound reads
    in_word(32'hC000_0001);
    in_word(32'hC000_0002);
    rd_net(32'hC000_0001, "R7 first word");
    rd_net(32'hC000_0002, "R7 second word");
    dec_rd_net = 1;
    @(negedge clk);
    chk(dec_stall == 1, "R8 stall on empty", {31'b0, dec_stall}, 1);
    @(posedge clk); #1;
    dec_rd_net = 0;
    in_word(32'hC000_0003);
    rd_net(32'hC000_0003, "R8 no pop while empty then word");

    // R9 inbound full
    for (int i = 0; i < 4; i++) in_word(32'hD000_0000 + i);
    @(negedge clk);
    chk(net_in_ready == 0, "R9 not ready when full", {31'b0, net_in_ready}, 0);
    @(posedge clk); #1;
    in_word(32'hEEEE_EEEE);
    for (int i = 0; i < 4; i++) rd_net(32'hD000_0000 + i, "R9 order and dropped word");
    dec_rd_net = 1;
    @(negedge clk);
    chk(dec_stall == 1, "R9 ignored word not stored", {31'b0, dec_stall}, 1);
    @(posedge clk); #1;
    dec_rd_net = 0;

    // R10 no pop during pipeline stall
    in_word(32'hF000_0001);
    for (int i = 0; i < 4; i++) net_wr(32'hA100_0000 + i, 0, 5'd0, 0);
    ex_valid = 1; ex_wr_net = 1; ex_result = 32'h1234_5678; dec_rd_net = 1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(pipe_stall == 1, "R10 stall active", {31'b0, pipe_stall}, 1);
      chk(dec_data == 32'hF000_0001, "R10 word held", dec_data, 32'hF000_0001);
      @(posedge clk); #1;
    end
    ex_valid = 0; ex_wr_net = 0;
    @(negedge clk);
    chk(dec_stall == 0 && dec_data == 32'hF000_0001, "R10 word not popped", dec_data, 32'hF000_0001);
    @(posedge clk); #1;
    @(negedge clk);
    chk(dec_stall == 1, "R10 popped after stall", {31'b0, dec_stall}, 1);
    @(posedge clk); #1;
    dec_rd_net = 0;
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule